// File: doc/BRIEF.md
# Freezable Event Counter Bank

A bank of performance counters behind a 32-bit register port. Slot 0 holds a 64-bit counter that advances on every clock that is not frozen. Every other slot holds a 32-bit counter that advances on each cycle in which the event input chosen by its 7-bit event number is high. Each slot has its own freeze bit, a condition-enable bit and an event select. A global control word can freeze all slots at once, enable the interrupt, and enable freezing on a condition.

A slot raises a condition when its counter's top bit is set. When the interrupt enable, the freeze-on-condition enable and that slot's condition enable are all on, `irq_o` goes high. In the same cycle every counter stops, and on the next edge hardware sets the global freeze bit. Software reads the counts, clears the top bit or the enables, and then clears the freeze bits to resume counting.

The register read port is combinational on `addr_i`. A write takes effect at the rising edge where `wr_en_i` is high.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, the global control word reads 0x8000_0000, each local control A word reads 0x8000_0000 (frozen), each local control B word and each count word reads 0, and `irq_o` is low.
- R2: The global control word is at offset 0x40: bit 31 is freeze-all, bit 30 is interrupt enable, bit 29 is freeze-on-condition enable, and the other bits read 0. Slot n (0..10) has control A at 0x50+0x10·n (bit 31 freeze, bit 26 condition enable, bits 22:16 event select, other bits read 0), a 32-bit storage word B at 0x54+0x10·n, and its count at 0x58+0x10·n.
- R3: A counter in slot 1..10 increases by exactly one at each rising edge where `evt_i[select]` is 1 and the counter is not frozen. It does not move when the selected event bit is 0, even if other event bits are 1.
- R4: The slot 0 counter is 64 bits wide, with its low word at 0x58 and its high word at 0x5C. It increases by one at every rising edge where it is not frozen, and the carry passes from the low word into the high word.
- R5: A counter holds its value while its own freeze bit is set or while freeze-all is set. Freeze-all overrides a cleared local freeze bit. Clearing both freeze bits resumes counting.
- R6: `irq_o` is 1 exactly when the interrupt enable and the freeze-on-condition enable are both 1 and at least one slot with its condition enable set has its counter's top bit at 1. It falls when that bit is cleared or when either enable is cleared.
- R7: While `irq_o` is 1, no counter advances. At the next rising edge, freeze-all becomes 1, and this hardware set wins over a software write of 0 in the same cycle.
- R8: A write to a count word loads that word and takes priority over an increment at the same edge. Writing 0 clears it.
- R9: Reads of unmapped offsets return 0, and writes to them change nothing. Unmapped offsets are 0x00–0x3F, 0x44–0x4F, any offset with address bits 1:0 not equal to 0, and 0x5C+0x10·n for n ≥ 1.
- R10: For slot 0, the event select field is stored but has no effect on counting. The top bit of slot 0 is bit 63, and it raises the condition just as bit 31 does for the 32-bit slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| evt_i | input | EVT_W (128) | Event input vector indexed by event select |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default parameters: eleven slots, 32-bit event counters, a 64-bit cycle counter and a 128-bit event vector. This brings event numbers 0 and 127 within reach, as well as the last slot at offset 0xF8 and the unused high-word offset of every event slot. The interrupt and the 64-bit carry would take billions of cycles to reach by counting, so the bench presets count words to just below the top bit or the low-word boundary. It then checks the exact cycle in which the bit rises, the interrupt appears and all counters stop.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned SEL_W    = 7;
  localparam int unsigned FRZ_BIT  = 31;
  localparam int unsigned IEN_BIT  = 30;
  localparam int unsigned CFRZ_BIT = 29;
  localparam int unsigned CE_BIT   = 26;
  localparam int unsigned SEL_LSB  = 16;
  localparam logic [ADDR_W-1:0] GLB_OFS   = 8'h40;
  localparam logic [3:0]        SLOT_BASE = 4'h5;  // addr[7:4] of slot 0

  typedef enum logic [1:0] {
    SUB_CTLA = 2'd0,
    SUB_CTLB = 2'd1,
    SUB_LO   = 2'd2,
    SUB_HI   = 2'd3
  } sub_e;

  typedef struct packed {
    logic             frz;
    logic             ce;
    logic [SEL_W-1:0] sel;
  } loc_ctl_t;
endpackage

// File: rtl/evt_bank_dec.sv
module evt_bank_dec
  import evt_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              glb_hit_o,
  output logic [NUM_CNT-1:0] slot_hit_o,
  output sub_e              sub_o
);
  logic [3:0] idx;
  logic       zone;

  assign idx       = addr_i[7:4] - SLOT_BASE;
  assign zone      = (addr_i[7:4] >= SLOT_BASE) && (addr_i[1:0] == 2'b00);
  assign sub_o     = sub_e'(addr_i[3:2]);
  assign glb_hit_o = (addr_i == GLB_OFS);

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_hit
    // high word exists only for the wide cycle slot
    assign slot_hit_o[n] = zone && (idx == 4'(n)) && ((sub_o != SUB_HI) || (n == 0));
  end

  p_onehot_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({glb_hit_o, slot_hit_o}));
  p_hi_only_slot0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_o == SUB_HI) |-> (slot_hit_o[NUM_CNT-1:1] == '0));
endmodule

// File: rtl/evt_bank_glb.sv
module evt_bank_glb
  import evt_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             cond_any_i,
  output logic [REG_W-1:0] ctl_o,
  output logic             irq_o,
  output logic             frz_all_o
);
  logic fac_q, ien_q, cfrz_q;

  assign irq_o     = ien_q & cfrz_q & cond_any_i;
  assign frz_all_o = fac_q | irq_o;  // stop in the cycle the condition appears

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_q  <= 1'b1;
      ien_q  <= 1'b0;
      cfrz_q <= 1'b0;
    end else begin
      if (wr_i) begin
        ien_q  <= wdata_i[IEN_BIT];
        cfrz_q <= wdata_i[CFRZ_BIT];
      end
      if (irq_o)     fac_q <= 1'b1;
      else if (wr_i) fac_q <= wdata_i[FRZ_BIT];
    end
  end

  always_comb begin
    ctl_o           = '0;
    ctl_o[FRZ_BIT]  = fac_q;
    ctl_o[IEN_BIT]  = ien_q;
    ctl_o[CFRZ_BIT] = cfrz_q;
  end

  p_irq_sets_fac_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> fac_q);
  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl_o[IEN_BIT] && ctl_o[CFRZ_BIT]));
endmodule

// File: rtl/evt_slot.sv
module evt_slot
  import evt_bank_pkg::*;
#(
  parameter int unsigned CW    = 32,
  parameter bit          CYCLE = 1'b0,
  parameter int unsigned EVT_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frz_all_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             hit_i,
  input  sub_e             sub_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctla_o,
  output logic [REG_W-1:0] ctlb_o,
  output logic [REG_W-1:0] lo_o,
  output logic [REG_W-1:0] hi_o,
  output logic             cond_o
);
  localparam int unsigned EVT_N = 1 << SEL_W;

  loc_ctl_t         ctl_q;
  logic [REG_W-1:0] ctlb_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [EVT_N-1:0] evt_pad;
  logic             wr_a, wr_b, wr_lo, wr_any, ev_hit, inc;

  assign wr_a  = wr_en_i & hit_i & (sub_i == SUB_CTLA);
  assign wr_b  = wr_en_i & hit_i & (sub_i == SUB_CTLB);
  assign wr_lo = wr_en_i & hit_i & (sub_i == SUB_LO);

  always_comb begin
    evt_pad            = '0;
    evt_pad[EVT_W-1:0] = evt_i;
  end

  assign ev_hit = CYCLE ? 1'b1 : evt_pad[ctl_q.sel];
  assign inc    = !frz_all_i && !ctl_q.frz && ev_hit;

  if (CW > REG_W) begin : g_wide
    logic wr_hi;
    assign wr_hi  = wr_en_i & hit_i & (sub_i == SUB_HI);
    assign wr_any = wr_lo | wr_hi;
    always_comb begin
      cnt_d = cnt_q;
      if (wr_lo) cnt_d[REG_W-1:0]  = wdata_i;
      if (wr_hi) cnt_d[CW-1:REG_W] = wdata_i[CW-REG_W-1:0];
      if (!wr_any && inc) cnt_d = cnt_q + CW'(1);
    end
    assign lo_o = cnt_q[REG_W-1:0];
    assign hi_o = REG_W'(cnt_q[CW-1:REG_W]);
  end else begin : g_narrow
    assign wr_any = wr_lo;
    always_comb begin
      if (wr_lo) cnt_d = CW'(wdata_i);
      else       cnt_d = cnt_q + CW'(inc);
    end
    assign lo_o = REG_W'(cnt_q);
    assign hi_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '{frz: 1'b1, ce: 1'b0, sel: '0};
      ctlb_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_a) ctl_q <= '{frz: wdata_i[FRZ_BIT], ce: wdata_i[CE_BIT],
                           sel: wdata_i[SEL_LSB +: SEL_W]};
      if (wr_b) ctlb_q <= wdata_i;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ctla_o                      = '0;
    ctla_o[FRZ_BIT]             = ctl_q.frz;
    ctla_o[CE_BIT]              = ctl_q.ce;
    ctla_o[SEL_LSB +: SEL_W]    = ctl_q.sel;
  end
  assign ctlb_o = ctlb_q;
  assign cond_o = ctl_q.ce & cnt_q[CW-1];

  p_hold_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((frz_all_i || ctla_o[FRZ_BIT]) && !wr_any) |=> $stable(cnt_q));
  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (lo_o == $past(wdata_i)));
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))));
  if (CYCLE) begin : g_cyc_chk
    p_cycle_steps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frz_all_i && !ctla_o[FRZ_BIT] && !wr_any) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 11,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CYC_W   = 64,
  parameter int unsigned EVT_W   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  logic               glb_hit, frz_all;
  logic [NUM_CNT-1:0] slot_hit, cond;
  sub_e               sub;
  logic [REG_W-1:0]   glb_ctl;
  logic [REG_W-1:0]   ctla_w [NUM_CNT];
  logic [REG_W-1:0]   ctlb_w [NUM_CNT];
  logic [REG_W-1:0]   lo_w   [NUM_CNT];
  logic [REG_W-1:0]   hi_w   [NUM_CNT];

  evt_bank_dec #(.NUM_CNT(NUM_CNT)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .glb_hit_o  (glb_hit),
    .slot_hit_o (slot_hit),
    .sub_o      (sub)
  );

  evt_bank_glb u_glb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i & glb_hit),
    .wdata_i    (wdata_i),
    .cond_any_i (|cond),
    .ctl_o      (glb_ctl),
    .irq_o      (irq_o),
    .frz_all_o  (frz_all)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
    localparam bit          IS_CYC = (n == 0);
    localparam int unsigned W      = IS_CYC ? CYC_W : CNT_W;
    evt_slot #(.CW(W), .CYCLE(IS_CYC), .EVT_W(EVT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .frz_all_i (frz_all),
      .evt_i     (evt_i),
      .hit_i     (slot_hit[n]),
      .sub_i     (sub),
      .wr_en_i   (wr_en_i),
      .wdata_i   (wdata_i),
      .ctla_o    (ctla_w[n]),
      .ctlb_o    (ctlb_w[n]),
      .lo_o      (lo_w[n]),
      .hi_o      (hi_w[n]),
      .cond_o    (cond[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (glb_hit) rdata_o = glb_ctl;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (slot_hit[n]) begin
        case (sub)
          SUB_CTLA: rdata_o = ctla_w[n];
          SUB_CTLB: rdata_o = ctlb_w[n];
          SUB_LO:   rdata_o = lo_w[n];
          default:  rdata_o = hi_w[n];
        endcase
      end
    end
  end

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_hit && (slot_hit == '0)) |-> (rdata_o == '0));
  p_irq_no_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond == '0) |-> !irq_o);
endmodule

// File: tb/tb_evt_counter_bank.sv
module tb_evt_counter_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] evt = '0;
  logic         irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  evt_counter_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // table: slot, select, event bit driven (255 = all), enabled cycles, expected count
  localparam int NV = 6;
  localparam int T_SLOT [NV] = '{1,   2,   3, 10,  4,  7};
  localparam int T_SEL  [NV] = '{5, 127,   0, 64, 12, 33};
  localparam int T_BIT  [NV] = '{5, 127,   1, 64, 255, 33};
  localparam int T_N    [NV] = '{7,   3,   5, 10,  1, 20};
  localparam int T_EXP  [NV] = '{7,   3,   0, 10,  1, 20};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // caller is at a negedge; write lands on the next posedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // release freeze-all for exactly n counting edges (n >= 1)
  task automatic run(input int n);
    wr(8'h40, 32'h0);
    repeat (n - 1) @(negedge clk);
    wr(8'h40, 32'h8000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0a;
    logic [7:0]  oa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h40, v); chk("R1 global", v, 32'h8000_0000);
    rd(8'h50, v); chk("R1 ctlA0", v, 32'h8000_0000);
    rd(8'hF0, v); chk("R1 ctlA10", v, 32'h8000_0000);
    rd(8'h54, v); chk("R1 ctlB0", v, 32'h0);
    rd(8'h58, v); chk("R1 cnt0 lo", v, 32'h0);
    rd(8'h5C, v); chk("R1 cnt0 hi", v, 32'h0);
    rd(8'hF8, v); chk("R1 cnt10", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 field layout
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R2 global fields", v, 32'hE000_0000);
    wr(8'h40, 32'h8000_0000);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, v); chk("R2 ctlA3 fields", v, 32'h847F_0000);
    wr(8'h80, 32'h8000_0000);
    wr(8'h74, 32'hDEAD_BEEF);
    rd(8'h74, v); chk("R2 ctlB2 storage", v, 32'hDEAD_BEEF);

    // R3 event selection table
    for (int i = 0; i < NV; i++) begin
      oa = 8'(8'h50 + 16 * T_SLOT[i]);
      wr(oa, 32'(T_SEL[i]) << 16);
      wr(oa + 8'h8, 32'h0);
      evt = (T_BIT[i] == 255) ? '1 : (128'b1 << T_BIT[i]);
      run(T_N[i]);
      rd(oa + 8'h8, v);
      chk($sformatf("R3 vector %0d", i), v, 32'(T_EXP[i]));
    end

    // R5 local and global freeze
    evt = '1;
    wr(8'h60, 32'h8005_0000);
    wr(8'h68, 32'h0);
    run(5);
    rd(8'h68, v); chk("R5 local freeze holds", v, 32'h0);
    wr(8'h60, 32'h0005_0000);
    repeat (5) @(negedge clk);
    rd(8'h68, v); chk("R5 global overrides local", v, 32'h0);
    run(2);
    rd(8'h68, v); chk("R5 resume", v, 32'h2);

    // R4 / R10 cycle counter ignores select and events
    evt = '0;
    wr(8'h50, 32'h007F_0000);
    wr(8'h58, 32'h0);
    wr(8'h5C, 32'h0);
    run(9);
    rd(8'h58, v); chk("R4 R10 cycles no events", v, 32'h9);
    wr(8'h58, 32'hFFFF_FFFE);
    run(3);
    rd(8'h58, v); chk("R4 carry lo", v, 32'h1);
    rd(8'h5C, v); chk("R4 carry hi", v, 32'h1);

    // R8 write beats increment
    evt = '1;
    wr(8'h40, 32'h0);
    wr(8'h68, 32'h100);
    rd(8'h68, v); chk("R8 write wins", v, 32'h100);
    @(negedge clk);
    rd(8'h68, v); chk("R8 counting after write", v, 32'h101);
    wr(8'h40, 32'h8000_0000);
    wr(8'h68, 32'h0);
    rd(8'h68, v); chk("R8 clear", v, 32'h0);

    // R6 / R7 overflow interrupt and hardware freeze
    evt = 128'b1 << 3;
    wr(8'h70, 32'h0403_0000);
    wr(8'h78, 32'h7FFF_FFFD);
    wr(8'h40, 32'h6000_0000);
    @(negedge clk);
    @(negedge clk);
    rd(8'h78, v); chk("R6 below msb", v, 32'h7FFF_FFFF);
    chk("R6 irq low before msb", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rd(8'h78, v); chk("R6 msb reached", v, 32'h8000_0000);
    chk("R6 irq on msb", {31'b0, irq}, 32'h1);
    rd(8'h58, c0a);
    repeat (3) @(negedge clk);
    rd(8'h78, v); chk("R7 event counter stopped", v, 32'h8000_0000);
    rd(8'h58, v); chk("R7 cycle counter stopped", v, c0a);
    rd(8'h40, v); chk("R7 freeze-all set by hw", v, 32'hE000_0000);
    wr(8'h40, 32'h6000_0000);
    rd(8'h40, v); chk("R7 hw set beats sw clear", v, 32'hE000_0000);
    wr(8'h78, 32'h0);
    chk("R6 irq drops on msb clear", {31'b0, irq}, 32'h0);
    wr(8'h78, 32'h8000_0000);
    chk("R6 irq with enables", {31'b0, irq}, 32'h1);
    wr(8'h40, 32'h8000_0000);
    chk("R6 irq drops on enable clear", {31'b0, irq}, 32'h0);
    wr(8'h70, 32'h8003_0000);
    wr(8'h40, 32'hE000_0000);
    chk("R6 no irq without local enable", {31'b0, irq}, 32'h0);
    wr(8'h40, 32'h8000_0000);
    wr(8'h78, 32'h0);

    // R10 64-bit top bit condition
    wr(8'h5C, 32'h8000_0000);
    wr(8'h50, 32'h0400_0000);
    wr(8'h40, 32'h6000_0000);
    chk("R10 irq from bit 63", {31'b0, irq}, 32'h1);
    rd(8'h58, c0a);
    repeat (2) @(negedge clk);
    rd(8'h58, v); chk("R10 cycle counter frozen", v, c0a);
    wr(8'h5C, 32'h0);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    wr(8'h40, 32'h8000_0000);

    // R9 unmapped offsets
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R9 0x44 reads zero", v, 32'h0);
    rd(8'h4C, v); chk("R9 0x4C reads zero", v, 32'h0);
    rd(8'h00, v); chk("R9 0x00 reads zero", v, 32'h0);
    rd(8'h42, v); chk("R9 misaligned reads zero", v, 32'h0);
    rd(8'h68, v); chk("R9 pre cnt1", v, 32'h0);
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h6C, v); chk("R9 no high word slot1", v, 32'h0);
    rd(8'h68, v); chk("R9 slot1 untouched", v, 32'h0);
    wr(8'h6A, 32'hFFFF_FFFF);
    rd(8'h68, v); chk("R9 misaligned write ignored", v, 32'h0);
    rd(8'h40, v); chk("R9 global untouched", v, 32'h8000_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule